// File: doc/BRIEF.md
# Duty-Ratio Search Engine

This block searches for the pair of 8-bit run and stall counts that brings a clock-suspension duty cycle closest to a requested effective frequency. It receives three values: a requested frequency, the full-speed frequency (both in kHz), and an upper limit on the total period length. A start pulse launches the search. The engine then steps the candidate total period from the limit down to one.

For each candidate total it computes two results on one shared multi-cycle restoring divider. The first is the run count (the slices with the core clock active). The second is the frequency that run count gives. The engine keeps the candidate whose frequency has the smallest absolute distance from the request. When the search ends it raises a one-cycle done pulse. The run count, the stall count and the achieved frequency then stay on the outputs until the next accepted start.

Equal errors replace the current best. Because the walk goes downward, the shortest period with the best error wins, which gives the shortest modulation latency. Writing the counts into the modulation hardware and clamping to policy limits belong to the surrounding logic.

Top module: `duty_search`

## Requirements
- R1: After reset, busy_o and done_o are 0, off_cnt_o is 1, on_cnt_o is 0 and freq_o is 0.
- R2: A start_i pulse while idle latches the request, the full-speed frequency and the total limit. busy_o is 1 from the cycle after the accepted start until the search ends.
- R3: For candidate total i, the run count is OFF = floor(req × i / full) taken modulo 256. The stall count is ON = (i − OFF) modulo 256. The candidate frequency is floor(full × OFF / i).
- R4: A candidate replaces the best when |freq − req| is less than or equal to the best error. Totals are visited from the limit down to 1, so the smallest total with the minimum error is reported.
- R5: The best result starts each search as freq = full, OFF = 1, ON = 0. A limit of 0, or a search in which no candidate reaches the starting error, reports exactly these values.
- R6: A total limit above 255 is treated as 255.
- R7: done_o is high for exactly one cycle, and busy_o is still 1 in that cycle. In the following cycle both are 0.
- R8: A start_i pulse while busy_o is 1 is ignored: the running search finishes with the values latched first, and no extra done_o pulse follows.
- R9: on_cnt_o, off_cnt_o and freq_o stay unchanged after done_o until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| req_khz_i | input | 24 | Requested effective frequency in kHz |
| full_khz_i | input | 24 | Full-speed frequency in kHz, nonzero |
| max_dur_i | input | 9 | Upper limit on the total period, in slices |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle search-complete pulse |
| on_cnt_o | output | 8 | Best stall count |
| off_cnt_o | output | 8 | Best run count |
| freq_o | output | 32 | Achieved frequency of the best pair, in kHz |

## Verification
The bench drives an exact half-speed request, where totals 2, 4, 6 and so on all give zero error. A design that used strict improvement, or walked upward, would report a longer period instead of 1/1. It also drives a request equal to full speed, a limit of zero, a limit of one whose only candidate is worse than the starting point, and a limit above 255. A design with a wrong starting best or a missing clamp would report other counts in these cases. A second start issued mid-search would, in a design that does not guard it, restart with new inputs or produce a second done pulse.

// File: rtl/duty_pkg.sv
package duty_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OFF_GO,
    S_OFF_WAIT,
    S_FRQ_GO,
    S_FRQ_WAIT,
    S_DONE
  } search_state_t;

  // absolute distance between two unsigned quantities
  function automatic logic [63:0] abs_gap(input logic [63:0] a, input logic [63:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/udiv_iter.sv
module udiv_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, q_q, dnd_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    trial, diff;
  logic          fits;

  assign trial = {rem_q, q_q[W-1]};
  assign diff  = trial - {1'b0, dsr_q};
  assign fits  = (trial >= {1'b0, dsr_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      q_q   <= '0;
      dnd_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_q <= '0;
        q_q   <= dividend;
        dnd_q <= dividend;
        dsr_q <= divisor;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
        q_q   <= {q_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        done  <= (cnt_q == CW'(1));
      end
    end
  end

  assign quot = q_q;

  // R3
  div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dsr_q != '0) |->
      ((2*W)'(q_q) * (2*W)'(dsr_q) + (2*W)'(rem_q) == (2*W)'(dnd_q)) && (rem_q < dsr_q));

endmodule

// File: rtl/best_keep.sv
module best_keep #(
  parameter int PW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [PW-1:0] init_freq,
  input  logic          upd,
  input  logic [CW-1:0] cand_off,
  input  logic [CW-1:0] cand_on,
  input  logic [PW-1:0] cand_freq,
  input  logic [PW-1:0] target,
  output logic [CW-1:0] best_off,
  output logic [CW-1:0] best_on,
  output logic [PW-1:0] best_freq,
  output logic          take
);
  import duty_pkg::*;

  logic [63:0] cand_err, best_err;

  assign cand_err = abs_gap(64'(cand_freq), 64'(target));
  assign best_err = abs_gap(64'(best_freq), 64'(target));
  assign take     = upd && (cand_err <= best_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_off  <= CW'(1);
      best_on   <= '0;
      best_freq <= '0;
    end else if (clr) begin
      best_off  <= CW'(1);
      best_on   <= '0;
      best_freq <= init_freq;
    end else if (take) begin
      best_off  <= cand_off;
      best_on   <= cand_on;
      best_freq <= cand_freq;
    end
  end

  // R4
  err_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> best_err <= $past(best_err));

endmodule

// File: rtl/duty_search.sv
module duty_search #(
  parameter int FREQ_W   = 24,
  parameter int CNT_W    = 8,
  parameter int DUR_IN_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [FREQ_W-1:0]         req_khz_i,
  input  logic [FREQ_W-1:0]         full_khz_i,
  input  logic [DUR_IN_W-1:0]       max_dur_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [CNT_W-1:0]          on_cnt_o,
  output logic [CNT_W-1:0]          off_cnt_o,
  output logic [FREQ_W+CNT_W-1:0]   freq_o
);
  import duty_pkg::*;

  localparam int PROD_W  = FREQ_W + CNT_W;
  localparam int MAX_DUR = (1 << CNT_W) - 1;

  search_state_t state;
  logic [FREQ_W-1:0] req_q, full_q;
  logic [CNT_W-1:0]  idx_q, off_q, dur_clamp;
  logic [PROD_W-1:0] div_dnd, div_dsr, div_quot;
  logic              div_go, div_done, accept, cand_vld, take_w;

  assign accept    = start_i && (state == S_IDLE);
  assign dur_clamp = (max_dur_i > DUR_IN_W'(MAX_DUR)) ? CNT_W'(MAX_DUR)
                                                      : max_dur_i[CNT_W-1:0];
  assign div_go    = (state == S_OFF_GO) || (state == S_FRQ_GO);
  assign div_dnd   = (state == S_OFF_GO) ? PROD_W'(req_q) * PROD_W'(idx_q)
                                         : PROD_W'(full_q) * PROD_W'(off_q);
  assign div_dsr   = (state == S_OFF_GO) ? PROD_W'(full_q) : PROD_W'(idx_q);
  assign cand_vld  = (state == S_FRQ_WAIT) && div_done;

  udiv_iter #(.W(PROD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .dividend(div_dnd), .divisor(div_dsr),
    .done(div_done), .quot(div_quot)
  );

  best_keep #(.PW(PROD_W), .CW(CNT_W)) u_best (
    .clk(clk), .rst_n(rst_n),
    .clr(accept), .init_freq(PROD_W'(full_khz_i)),
    .upd(cand_vld), .cand_off(off_q), .cand_on(idx_q - off_q),
    .cand_freq(div_quot), .target(PROD_W'(req_q)),
    .best_off(off_cnt_o), .best_on(on_cnt_o), .best_freq(freq_o),
    .take(take_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      req_q  <= '0;
      full_q <= '0;
      idx_q  <= '0;
      off_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start_i) begin
          req_q  <= req_khz_i;
          full_q <= full_khz_i;
          idx_q  <= dur_clamp;
          state  <= (dur_clamp == '0) ? S_DONE : S_OFF_GO;
        end
        S_OFF_GO:   state <= S_OFF_WAIT;
        S_OFF_WAIT: if (div_done) begin
          off_q <= div_quot[CNT_W-1:0];
          state <= S_FRQ_GO;
        end
        S_FRQ_GO:   state <= S_FRQ_WAIT;
        S_FRQ_WAIT: if (div_done) begin
          if (idx_q == CNT_W'(1)) state <= S_DONE;
          else begin
            idx_q <= idx_q - 1'b1;
            state <= S_OFF_GO;
          end
        end
        S_DONE:     state <= S_IDLE;
        default:    state <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state != S_IDLE);
  assign done_o = (state == S_DONE);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(req_q) && $stable(full_q));

  // R4
  take_only_on_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |-> (state == S_FRQ_WAIT));

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(freq_o) && $stable(on_cnt_o) && $stable(off_cnt_o));

endmodule

// File: tb/duty_search_bench.sv
module duty_search_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] req_khz_i = '0, full_khz_i = '0;
  logic [8:0]  max_dur_i = '0;
  logic        busy_o, done_o;
  logic [7:0]  on_cnt_o, off_cnt_o;
  logic [31:0] freq_o;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [47:0] exp_q[$];
  string       tag_q[$];
  logic [47:0] last_exp;

  always #2.5 clk = ~clk;

  duty_search u_duty_search (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .req_khz_i(req_khz_i), .full_khz_i(full_khz_i), .max_dur_i(max_dur_i),
    .busy_o(busy_o), .done_o(done_o),
    .on_cnt_o(on_cnt_o), .off_cnt_o(off_cnt_o), .freq_o(freq_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // independent model: {on, off, freq}
  function automatic logic [47:0] model(input longint req, input longint full, input longint dur);
    longint bf = full, bo = 1, bn = 0, d, o, n, f, ce, be;
    d = (dur > 255) ? 255 : dur;
    for (longint i = d; i > 0; i--) begin
      o = ((req * i) / full) % 256;
      n = (i - o + 256) % 256;
      f = (full * o) / i;
      ce = (f > req) ? f - req : req - f;
      be = (bf > req) ? bf - req : req - bf;
      if (ce <= be) begin bf = f; bo = o; bn = n; end
    end
    return {8'(bn), 8'(bo), 32'(bf)};
  endfunction

  task automatic pulse_start(input int req, input int full, input int dur);
    @(negedge clk);
    req_khz_i = 24'(req); full_khz_i = 24'(full); max_dur_i = 9'(dur);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run(input int req, input int full, input int dur, input string tag,
                     input bit use_fixed, input logic [47:0] fixed);
    logic [47:0] e;
    e = use_fixed ? fixed : model(req, full, dur);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_exp = e;
    pulse_start(req, full, dur);
    check(busy_o == 1'b1, "R2 busy after start", longint'(busy_o), 1);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check({on_cnt_o, off_cnt_o, freq_o} == last_exp, "R9 result held",
          longint'({on_cnt_o, off_cnt_o, freq_o}), longint'(last_exp));
  endtask

  // monitor
  always begin
    @(negedge clk);
    if (done_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        logic [47:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(busy_o == 1'b1, {t, " R7 busy in done"}, longint'(busy_o), 1);
        check(on_cnt_o == e[47:40], {t, " on"}, longint'(on_cnt_o), longint'(e[47:40]));
        check(off_cnt_o == e[39:32], {t, " off"}, longint'(off_cnt_o), longint'(e[39:32]));
        check(freq_o == e[31:0], {t, " freq"}, longint'(freq_o), longint'(e[31:0]));
        @(negedge clk);
        check(!done_o && !busy_o, {t, " R7 one-cycle done"}, longint'({done_o, busy_o}), 0);
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      check(1'b0, "watchdog", cyc, 190000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(busy_o == 0 && done_o == 0, "R1 busy/done reset", longint'({busy_o, done_o}), 0);
    check(off_cnt_o == 1 && on_cnt_o == 0 && freq_o == 0, "R1 counts reset",
          longint'({on_cnt_o, off_cnt_o, freq_o}), longint'({8'd0, 8'd1, 32'd0}));
    // R4 tie: exact half speed, smallest total 2 wins
    run(100000, 200000, 10, "R4 tie", 1'b1, {8'd1, 8'd1, 32'd100000});
    // R3 general search across full range
    run(77777, 233333, 255, "R3 full range", 1'b0, '0);
    run(1000, 300000, 50, "R3 low request", 1'b0, '0);
    run(181818, 266666, 37, "R3 mid request", 1'b0, '0);
    // R5 zero limit and no improving candidate
    run(50000, 200000, 0, "R5 zero limit", 1'b1, {8'd0, 8'd1, 32'd200000});
    run(120000, 200000, 1, "R5 no better", 1'b1, {8'd0, 8'd1, 32'd200000});
    // R4 full speed request: total 1 wins
    run(200000, 200000, 40, "R4 full speed", 1'b1, {8'd0, 8'd1, 32'd200000});
    // R6 clamp
    run(150000, 266640, 300, "R6 clamp", 1'b1, model(150000, 266640, 255));
    // R8 start while busy
    begin
      logic [47:0] e;
      e = model(90000, 210000, 30);
      exp_q.push_back(e);
      tag_q.push_back("R8 first wins");
      last_exp = e;
      pulse_start(90000, 210000, 30);
      repeat (10) @(negedge clk);
      pulse_start(5000, 100000, 3);
      while (exp_q.size() != 0) @(negedge clk);
      repeat (20) @(negedge clk);
      check({on_cnt_o, off_cnt_o, freq_o} == last_exp, "R8 result kept",
            longint'({on_cnt_o, off_cnt_o, freq_o}), longint'(last_exp));
    end
    finish_run();
  end
endmodule